// File: doc/BRIEF.md
# Wide Split-Word External Register

This block is a register that lives outside a generated register block and is reached through a strobe-and-acknowledge request interface. Its contents are wider than the processor's data bus, so they are split into bus-wide sub-words. The request arrives as a vector with one strobe bit per sub-word. That bit alone picks the sub-word to read or write, so the endpoint has no address input.

Writes pass through per-bit enables, so only the enabled bits of the chosen sub-word change. Reads return the chosen sub-word together with a one-cycle read acknowledge. A latency parameter selects when the acknowledge comes. A value of zero answers in the request cycle. A positive value answers that many cycles later, and the read word is taken when the request is accepted. The full contents are always visible to the surrounding hardware on a wide output.

Two presence parameters describe registers that cannot be read or cannot be written. A missing read side never acknowledges and always drives zero read data. A missing write side ignores write strobes and keeps its reset value.

Top module: `wide_ext_reg`

## Requirements
- R1: After reset, `reg_value` equals the `RESET_VAL` parameter. Sub-word i occupies bits [i*SUBW +: SUBW] of `reg_value`.
- R2: A write request with strobe bit i set changes only those bits of sub-word i whose `wr_biten` bit is 1; they take the matching bits of `wr_data`. All other bits keep their value. The change shows on `reg_value` from the cycle after the request cycle.
- R3: In the cycle where `rd_ack` is 1, `rd_data` carries sub-word i of the contents, where i is the strobe bit of that read.
- R4: `rd_data` is all zeros in every cycle where `rd_ack` is 0.
- R5: With `ACK_LAT` = 0, `rd_ack` is 1 in the same cycle as a read request, and `wr_ack` is 1 in the same cycle as a write request.
- R6: With `ACK_LAT` = N > 0, a request receives exactly one acknowledge pulse, N cycles after the request cycle. The acknowledge is 0 in the cycles between. Read data reflects the contents as they were in the request cycle.
- R7: Each request has exactly one strobe bit set. With `ACK_LAT` > 0 at most one request is outstanding, and a new request may be issued in the cycle right after the acknowledge.
- R8: With `HAS_RD` = 0, read strobes are ignored: `rd_ack` stays 0 and `rd_data` stays zero.
- R9: With `HAS_WR` = 0, write strobes are ignored: `wr_ack` stays 0 and `reg_value` keeps its reset value.
- R10: `rd_ack` and `wr_ack` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NSUB | Request strobes, one per sub-word (bit i selects sub-word i) |
| req_is_wr | input | 1 | 1 = write request, 0 = read request |
| wr_data | input | SUBW | Write data, one bus word |
| wr_biten | input | SUBW | Per-bit write enables, active high |
| rd_ack | output | 1 | One-cycle read completion; qualifies rd_data |
| rd_data | output | SUBW | Read data of the selected sub-word, zero otherwise |
| wr_ack | output | 1 | One-cycle write completion |
| reg_value | output | NSUB*SUBW | Full register contents for the hardware side |

## Verification
The assertions assume that the bridge in front of the block sets at most one strobe bit per request. They also assume that, in delayed mode, it holds off any new strobe while an acknowledge is still owed. The bench keeps to both rules: it builds every strobe as a single shifted one, and it drives one request at a time and waits for that request's acknowledge cycle before starting the next. Random indices, data and enables are drawn from a seeded generator. Four instances cover the zero-latency, delayed, write-only and read-only variants.

// File: rtl/wer_pkg.sv
package wer_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Decide what an incoming request means for this variant of the register.
  function automatic acc_kind_t classify(input logic any_strobe,
                                         input logic is_write,
                                         input logic has_read,
                                         input logic has_write);
    acc_kind_t k;
    k = ACC_IDLE;
    if (any_strobe) begin
      if (is_write && has_write)
        k = ACC_WRITE;
      else if (!is_write && has_read)
        k = ACC_READ;
    end
    return k;
  endfunction

endpackage

// File: rtl/wer_sub_store.sv
module wer_sub_store #(
  parameter int          W        = 32,
  parameter logic [W-1:0] RST_WORD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_biten,
  output logic [W-1:0] q
);

  // Masked merge: enabled bits take the new data, the rest keep the old value.
  function automatic logic [W-1:0] mask_merge(input logic [W-1:0] old_v,
                                              input logic [W-1:0] new_v,
                                              input logic [W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

  logic [W-1:0] next_word;
  assign next_word = mask_merge(q, wr_data, wr_biten);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= RST_WORD;
    else if (wr_en)
      q <= next_word;
  end

endmodule

// File: rtl/wer_rd_select.sv
module wer_rd_select #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] words,
  output logic [W-1:0]   word_out
);

  // AND-OR selection: each strobe bit gates its own sub-word onto the result.
  always_comb begin
    word_out = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i])
        word_out = word_out | words[i*W +: W];
    end
  end

endmodule

// File: rtl/wer_ack_timer.sv
module wer_ack_timer #(
  parameter int LAT = 0,
  parameter int W   = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_go,
  input  logic         wr_go,
  input  logic [W-1:0] live_word,
  output logic         rd_ack,
  output logic         wr_ack,
  output logic [W-1:0] rd_data,
  output logic         busy
);

  localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1);

  generate
    if (LAT == 0) begin : g_zero
      // Same-cycle answer: nothing to remember between cycles.
      assign rd_ack  = rd_go;
      assign wr_ack  = wr_go;
      assign rd_data = rd_go ? live_word : '0;
      assign busy    = 1'b0;
    end else begin : g_delay
      logic             pend_q;
      logic             pend_wr_q;
      logic [CNT_W-1:0] cnt_q;
      logic [W-1:0]     hold_q;
      logic             accept;
      logic             last_cycle;

      assign accept     = (rd_go || wr_go) && !pend_q;
      assign last_cycle = pend_q && (cnt_q == CNT_W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q    <= 1'b0;
          pend_wr_q <= 1'b0;
          cnt_q     <= '0;
          hold_q    <= '0;
        end else if (accept) begin
          pend_q    <= 1'b1;
          pend_wr_q <= wr_go;
          cnt_q     <= CNT_W'(LAT);
          hold_q    <= rd_go ? live_word : '0;
        end else if (pend_q) begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (last_cycle)
            pend_q <= 1'b0;
        end
      end

      assign rd_ack  = last_cycle && !pend_wr_q;
      assign wr_ack  = last_cycle && pend_wr_q;
      assign rd_data = (last_cycle && !pend_wr_q) ? hold_q : '0;
      assign busy    = pend_q;
    end
  endgenerate

endmodule

// File: rtl/wide_ext_reg.sv
module wide_ext_reg
  import wer_pkg::*;
#(
  parameter int SUBW    = 32,
  parameter int NSUB    = 4,
  parameter int ACK_LAT = 0,
  parameter bit HAS_RD  = 1'b1,
  parameter bit HAS_WR  = 1'b1,
  parameter logic [SUBW*NSUB-1:0] RESET_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSUB-1:0]      req,
  input  logic                 req_is_wr,
  input  logic [SUBW-1:0]      wr_data,
  input  logic [SUBW-1:0]      wr_biten,
  output logic                 rd_ack,
  output logic [SUBW-1:0]      rd_data,
  output logic                 wr_ack,
  output logic [SUBW*NSUB-1:0] reg_value
);

  localparam int REG_W = SUBW * NSUB;

  // Named internal events, visible to the bound checker.
  acc_kind_t       acc_kind;
  logic            any_strobe;
  logic            rd_go;
  logic            wr_go;
  logic [SUBW-1:0] live_word;
  logic            timer_busy;
  logic [REG_W-1:0] contents;

  assign any_strobe = |req;
  assign acc_kind   = classify(any_strobe, req_is_wr, HAS_RD, HAS_WR);
  assign rd_go      = (acc_kind == ACC_READ);
  assign wr_go      = (acc_kind == ACC_WRITE);

  genvar gi;
  generate
    for (gi = 0; gi < NSUB; gi++) begin : g_word
      wer_sub_store #(
        .W        (SUBW),
        .RST_WORD (RESET_VAL[gi*SUBW +: SUBW])
      ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go && req[gi]),
        .wr_data  (wr_data),
        .wr_biten (wr_biten),
        .q        (contents[gi*SUBW +: SUBW])
      );
    end
  endgenerate

  wer_rd_select #(
    .W (SUBW),
    .N (NSUB)
  ) u_sel (
    .sel      (req),
    .words    (contents),
    .word_out (live_word)
  );

  wer_ack_timer #(
    .LAT (ACK_LAT),
    .W   (SUBW)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .live_word (live_word),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .rd_data   (rd_data),
    .busy      (timer_busy)
  );

  assign reg_value = contents;

endmodule

// File: rtl/wide_ext_reg_chk.sv
module wide_ext_reg_chk #(
  parameter int SUBW    = 32,
  parameter int NSUB    = 4,
  parameter int ACK_LAT = 0,
  parameter bit HAS_RD  = 1'b1,
  parameter bit HAS_WR  = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSUB-1:0]      req,
  input logic                 req_is_wr,
  input logic                 rd_ack,
  input logic                 wr_ack,
  input logic [SUBW-1:0]      rd_data,
  input logic [SUBW*NSUB-1:0] reg_value,
  input logic                 timer_busy
);

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $onehot0(req));

  // R7
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_busy |-> !(|req));

  // R4
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ack |-> (rd_data == '0));

  // R10
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ack && wr_ack));

  // R2
  hold_when_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|req) && req_is_wr) |=> $stable(reg_value));

  generate
    if (ACK_LAT == 0 && HAS_RD) begin : g_zero_rd
      // R5
      same_cycle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req) && !req_is_wr) |-> rd_ack);
    end
    if (ACK_LAT == 0 && HAS_WR) begin : g_zero_wr
      // R5
      same_cycle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req) && req_is_wr) |-> wr_ack);
    end
    if (ACK_LAT > 0) begin : g_delay
      // R6
      rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !rd_ack);
      // R6
      wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);
      // R6
      no_ack_in_req_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> !(rd_ack || wr_ack));
    end
    if (ACK_LAT > 1) begin : g_delay_long
      // R6
      no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> !(rd_ack || wr_ack));
    end
  endgenerate

endmodule

bind wide_ext_reg wide_ext_reg_chk #(
  .SUBW    (SUBW),
  .NSUB    (NSUB),
  .ACK_LAT (ACK_LAT),
  .HAS_RD  (HAS_RD),
  .HAS_WR  (HAS_WR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .req_is_wr  (req_is_wr),
  .rd_ack     (rd_ack),
  .wr_ack     (wr_ack),
  .rd_data    (rd_data),
  .reg_value  (reg_value),
  .timer_busy (timer_busy)
);

// File: tb/wide_ext_reg_test.sv
module wide_ext_reg_test;

  localparam int SUBW = 32;
  localparam int NSUB = 4;
  localparam int REGW = SUBW * NSUB;
  localparam logic [REGW-1:0] RSTV = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam int SLOW_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NSUB-1:0] req_v [4];
  logic            is_wr;
  logic [SUBW-1:0] wdata;
  logic [SUBW-1:0] wben;
  logic            rd_ack_v [4];
  logic            wr_ack_v [4];
  logic [SUBW-1:0] rd_data_v [4];
  logic [REGW-1:0] value_v [4];

  // Target 0: same-cycle; 1: delayed; 2: write-only; 3: read-only.
  int  lat_of [4]   = '{0, SLOW_LAT, 0, 0};
  bit  can_rd [4]   = '{1, 1, 0, 1};
  bit  can_wr [4]   = '{1, 1, 1, 0};
  logic [REGW-1:0] mdl [4];

  int checks = 0;
  int errors = 0;

  wide_ext_reg #(.SUBW(SUBW), .NSUB(NSUB), .ACK_LAT(0), .RESET_VAL(RSTV)) uut (
    .clk(clk), .rst_n(rst_n), .req(req_v[0]), .req_is_wr(is_wr), .wr_data(wdata),
    .wr_biten(wben), .rd_ack(rd_ack_v[0]), .rd_data(rd_data_v[0]),
    .wr_ack(wr_ack_v[0]), .reg_value(value_v[0]));

  wide_ext_reg #(.SUBW(SUBW), .NSUB(NSUB), .ACK_LAT(SLOW_LAT), .RESET_VAL(RSTV)) uut_slow (
    .clk(clk), .rst_n(rst_n), .req(req_v[1]), .req_is_wr(is_wr), .wr_data(wdata),
    .wr_biten(wben), .rd_ack(rd_ack_v[1]), .rd_data(rd_data_v[1]),
    .wr_ack(wr_ack_v[1]), .reg_value(value_v[1]));

  wide_ext_reg #(.SUBW(SUBW), .NSUB(NSUB), .ACK_LAT(0), .HAS_RD(1'b0), .RESET_VAL(RSTV)) uut_wo (
    .clk(clk), .rst_n(rst_n), .req(req_v[2]), .req_is_wr(is_wr), .wr_data(wdata),
    .wr_biten(wben), .rd_ack(rd_ack_v[2]), .rd_data(rd_data_v[2]),
    .wr_ack(wr_ack_v[2]), .reg_value(value_v[2]));

  wide_ext_reg #(.SUBW(SUBW), .NSUB(NSUB), .ACK_LAT(0), .HAS_WR(1'b0), .RESET_VAL(RSTV)) uut_ro (
    .clk(clk), .rst_n(rst_n), .req(req_v[3]), .req_is_wr(is_wr), .wr_data(wdata),
    .wr_biten(wben), .rd_ack(rd_ack_v[3]), .rd_data(rd_data_v[3]),
    .wr_ack(wr_ack_v[3]), .reg_value(value_v[3]));

  // Bit-by-bit model of a masked write to one sub-word.
  function automatic logic [REGW-1:0] apply_write(input logic [REGW-1:0] cur, input int idx,
                                                  input logic [SUBW-1:0] d,
                                                  input logic [SUBW-1:0] en);
    logic [REGW-1:0] r;
    r = cur;
    for (int b = 0; b < SUBW; b++)
      if (en[b]) r[idx*SUBW + b] = d[b];
    return r;
  endfunction

  function automatic logic [SUBW-1:0] word_of(input logic [REGW-1:0] v, input int idx);
    logic [SUBW-1:0] w;
    for (int b = 0; b < SUBW; b++) w[b] = v[idx*SUBW + b];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [REGW-1:0] act,
                       input logic [REGW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_resp(input int tgt, input bit e_rd, input bit e_wr,
                            input logic [SUBW-1:0] e_data, input string ack_tag,
                            input string data_tag);
    check({rd_ack_v[tgt], wr_ack_v[tgt]} == {e_rd, e_wr}, ack_tag,
          REGW'({rd_ack_v[tgt], wr_ack_v[tgt]}), REGW'({e_rd, e_wr}));
    check(rd_data_v[tgt] == e_data, data_tag, REGW'(rd_data_v[tgt]), REGW'(e_data));
    check(!(rd_ack_v[tgt] && wr_ack_v[tgt]), "R10", REGW'({rd_ack_v[tgt], wr_ack_v[tgt]}), '0);
  endtask

  task automatic access(input int tgt, input bit wr, input int idx,
                        input logic [SUBW-1:0] d, input logic [SUBW-1:0] en,
                        input string tag);
    bit e_rd;
    bit e_wr;
    logic [SUBW-1:0] e_data;
    string ack_tag;
    int lat;
    lat    = lat_of[tgt];
    e_rd   = !wr && can_rd[tgt];
    e_wr   = wr && can_wr[tgt];
    e_data = e_rd ? word_of(mdl[tgt], idx) : '0;
    ack_tag = (tag != "") ? tag : ((lat == 0) ? "R5" : "R6");
    @(posedge clk);
    #1;
    req_v[tgt] = NSUB'(1) << idx;
    is_wr = wr;
    wdata = d;
    wben  = en;
    @(negedge clk);
    if (lat == 0) check_resp(tgt, e_rd, e_wr, e_data, ack_tag, e_rd ? "R3" : "R4");
    else          check_resp(tgt, 1'b0, 1'b0, '0, ack_tag, "R4");
    @(posedge clk);
    #1;
    req_v[tgt] = '0;
    if (e_wr) mdl[tgt] = apply_write(mdl[tgt], idx, d, en);
    check(value_v[tgt] == mdl[tgt], can_wr[tgt] ? "R2" : "R9", value_v[tgt], mdl[tgt]);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == lat) check_resp(tgt, e_rd, e_wr, e_data, ack_tag, e_rd ? "R3" : "R4");
      else          check_resp(tgt, 1'b0, 1'b0, '0, ack_tag, "R4");
    end
  endtask

  initial begin
    for (int t = 0; t < 4; t++) begin
      req_v[t] = '0;
      mdl[t] = RSTV;
    end
    is_wr = 1'b0;
    wdata = '0;
    wben  = '0;
    void'($urandom(32'd2417));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset contents and quiet outputs
    for (int t = 0; t < 4; t++) begin
      check(value_v[t] == RSTV, "R1", value_v[t], RSTV);
      check(rd_data_v[t] == '0, "R4", REGW'(rd_data_v[t]), '0);
    end

    // Directed corners on the same-cycle instance.
    access(0, 1'b0, 3, '0, '0, "");                           // R3 read top sub-word at reset
    access(0, 1'b1, 0, 32'hFFFF_FFFF, 32'h0000_0000, "");     // R2 no enabled bits
    access(0, 1'b1, 1, 32'hA5A5_A5A5, 32'hFFFF_FFFF, "");     // R2 full word
    access(0, 1'b1, 2, 32'hFFFF_FFFF, 32'h8000_0001, "");     // R2 edge bits only
    access(0, 1'b0, 2, '0, '0, "");
    access(0, 1'b0, 1, '0, '0, "");

    // Random traffic on the same-cycle instance.
    for (int n = 0; n < 300; n++)
      access(0, 1'($urandom), int'($urandom % NSUB), $urandom, $urandom, "");

    // Delayed instance: back-to-back write then read of the same sub-word (R7).
    access(1, 1'b1, 3, 32'hDEAD_BEEF, 32'hFFFF_0000, "R7");
    access(1, 1'b0, 3, '0, '0, "R7");
    for (int n = 0; n < 40; n++)
      access(1, 1'($urandom), int'($urandom % NSUB), $urandom, $urandom, "");

    // Write-only variant: reads never answered (R8).
    for (int n = 0; n < 20; n++)
      access(2, 1'($urandom), int'($urandom % NSUB), $urandom, $urandom, "R8");

    // Read-only variant: writes ignored (R9).
    for (int n = 0; n < 20; n++)
      access(3, 1'($urandom), int'($urandom % NSUB), $urandom, $urandom, "R9");
    access(3, 1'b1, 0, 32'h0, 32'hFFFF_FFFF, "R9");
    @(negedge clk);
    check(value_v[3] == RSTV, "R9", value_v[3], RSTV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule